// File: doc/BRIEF.md
# Hierarchical Interrupt Status Encoder

This block collects three request vectors (critical, main and peripheral), applies per-source masks and folds them into one registered 32-bit status word. The word carries a pending flag and a lowest-index source number for each of the three levels, so that vectoring software can walk the levels with a single read. The levels are nested. Peripheral sources reach the upper levels through two reserved slots: a high-priority peripheral lights critical slot 2, and any other peripheral lights main slot 4. The software then reads the peripheral field to find the real source.

Peripheral slot 0 is not a pin. It stands for a whole 32-bit DMA interrupt group that has its own pending and mask registers. The group counts as active whenever any unmasked bit of its pending register is set. A single interrupt line to the CPU is the OR of the three level flags. It is registered together with the status word.

All registers are reached through a simple 32-bit bus. Writes take effect on the clock edge, and reads return data combinationally.

Top module: `irq_status_encoder`

## Requirements
- R1: In the status word, bit 10 is the critical flag and bits [9:8] the critical number, bit 21 is the main flag and bits [20:16] the main number, and bit 29 is the peripheral flag and bits [28:24] the peripheral number. Every other bit reads 0, and a level with nothing pending shows flag 0 and number 0.
- R2: Within each level the lowest-numbered active source is the one encoded.
- R3: Input bit 2 of the critical vector, bit 4 of the main vector and bit 0 of the peripheral vector have no effect, because those slots are fed internally.
- R4: An active peripheral whose bit is set in parameter HP_MAP (default: sources 1, 2 and 3) drives critical slot 2. Any other active peripheral drives main slot 4. The peripheral field always holds the lowest active peripheral.
- R5: While the critical flag is set, the main flag and the main number read 0.
- R6: Main mask register bit 16-n disables main source n, including slot 4, when it is 1.
- R7: Peripheral mask register bit 31-n disables peripheral source n, including the DMA group at source 0, when it is 1.
- R8: Each bit of the DMA pending register is set by a one-cycle event pulse and cleared by writing 1 to it. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: A 1 in the DMA mask register disables that pending bit. The DMA group is active when any pending bit with a 0 mask bit is set.
- R10: irq_o equals the OR of the three flags. irq_o and the status word both change on the first clock edge after an input change.
- R11: After reset the status word and irq_o read 0, the DMA pending register reads 0, and all mask bits read 1 (main mask 0x0001FFFF).
- R12: The register addresses are 0 for status (read-only), 1 for the main mask, 2 for the peripheral mask, 3 for DMA pending and 4 for the DMA mask. Other addresses read 0, and writes to address 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crit_req | input | 4 | Critical request vector (bit 2 unused) |
| main_req | input | 17 | Main request vector (bit 4 unused) |
| per_req | input | 32 | Peripheral request vector (bit 0 unused) |
| dma_evt | input | 32 | One-cycle DMA event pulses that set pending bits |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| status_o | output | 32 | Registered encoded status word |
| irq_o | output | 1 | Registered interrupt line to the CPU |

## Verification
The assertions assume that the request inputs are level-sensitive, that dma_evt is sampled on every edge as a set strobe, and that reset is held for at least one clock edge before any check is expected to hold. The bench changes all inputs only on falling edges. It holds each request pattern for two rising edges before sampling, and it opens or closes masks through bus writes that complete before the patterns that depend on them. This keeps each observed status word a pure function of stable inputs and register contents.

// File: rtl/irq_enc_pkg.sv
// Package: shared constants, status field positions and register selectors
// for the hierarchical interrupt status encoder.
// Assumes a fixed 32-bit status word whose field positions are decoded by
// software, so the positions are not parameters.
package irq_enc_pkg;

    localparam int CRIT_SLOTS = 4;
    localparam int MAIN_SLOTS = 17;
    localparam int PER_SLOTS  = 32;
    localparam int DMA_BITS   = 32;
    localparam int WORD_W     = 32;

    localparam int CRIT_NUM_W = $clog2(CRIT_SLOTS);
    localparam int MAIN_NUM_W = $clog2(MAIN_SLOTS);
    localparam int PER_NUM_W  = $clog2(PER_SLOTS);

    // Slots fed internally instead of from pins
    localparam int CRIT_HP_SLOT = 2;
    localparam int MAIN_LP_SLOT = 4;
    localparam int PER_DMA_SLOT = 0;

    // Status word layout
    localparam int CRIT_FLAG_BIT = 10;
    localparam int CRIT_NUM_LSB  = 8;
    localparam int MAIN_FLAG_BIT = 21;
    localparam int MAIN_NUM_LSB  = 16;
    localparam int PER_FLAG_BIT  = 29;
    localparam int PER_NUM_LSB   = 24;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_STATUS    = 3'd0,
        SEL_MAIN_MASK = 3'd1,
        SEL_PER_MASK  = 3'd2,
        SEL_DMA_PEND  = 3'd3,
        SEL_DMA_MASK  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_lowest_enc.sv
// Module: irq_lowest_enc
// Finds the lowest-numbered set bit of a request vector and reports its
// index together with an any-set flag. The index reads 0 when nothing is set.
// Assumes N >= 2.
module irq_lowest_enc #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    // Scan from the top down so the lowest set bit is written last
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end

    // Any request present
    assign any = |req;

endmodule

// File: rtl/irq_dma_group.sv
// Module: irq_dma_group
// Pending and mask registers for a group of DMA interrupt bits. Event pulses
// set pending bits, and bus writes of 1 clear them. When a set and a clear
// meet in the same cycle, the set wins. A mask bit of 1 disables its pending
// bit. Assumes event pulses last one clock.
module irq_dma_group #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] evt,
    input  logic            clr_we,
    input  logic [BITS-1:0] clr_data,
    input  logic            mask_we,
    input  logic [BITS-1:0] mask_data,
    output logic [BITS-1:0] pend_q,
    output logic [BITS-1:0] mask_q,
    output logic            active
);

    logic [BITS-1:0] clr_bits;
    logic [BITS-1:0] pend_d;

    // Bits to clear this cycle
    assign clr_bits = clr_we ? clr_data : '0;

    // Next pending value: clear first, then OR in new events
    assign pend_d = (pend_q & ~clr_bits) | evt;

    // Pending register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    // Mask register update, all disabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_data;
        end
    end

    // Group request: any pending bit that is not masked
    assign active = |(pend_q & ~mask_q);

endmodule

// File: rtl/irq_mask_regs.sv
// Module: irq_mask_regs
// Holds the main and peripheral mask registers and turns them into per-source
// enables. Register bit (SLOTS-1-n) disables source n, and a 1 means disabled.
// Assumes WORD_W is at least as wide as each slot count.
module irq_mask_regs #(
    parameter int MAIN_SLOTS = 17,
    parameter int PER_SLOTS  = 32,
    parameter int WORD_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  main_we,
    input  logic                  per_we,
    input  logic [WORD_W-1:0]     wdata,
    output logic [MAIN_SLOTS-1:0] main_mask_q,
    output logic [PER_SLOTS-1:0]  per_mask_q,
    output logic [MAIN_SLOTS-1:0] main_en,
    output logic [PER_SLOTS-1:0]  per_en
);

    // Main mask register, all disabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mask_q <= '1;
        end else if (main_we) begin
            main_mask_q <= wdata[MAIN_SLOTS-1:0];
        end
    end

    // Peripheral mask register, all disabled after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_mask_q <= '1;
        end else if (per_we) begin
            per_mask_q <= wdata[PER_SLOTS-1:0];
        end
    end

    // Reversed bit order: source n is controlled by the mirrored bit
    for (genvar n = 0; n < MAIN_SLOTS; n++) begin : g_main_en
        assign main_en[n] = ~main_mask_q[MAIN_SLOTS-1-n];
    end

    for (genvar n = 0; n < PER_SLOTS; n++) begin : g_per_en
        assign per_en[n] = ~per_mask_q[PER_SLOTS-1-n];
    end

endmodule

// File: rtl/irq_status_encoder.sv
// Module: irq_status_encoder (top)
// Masks the critical, main and peripheral request vectors, nests peripherals
// into critical slot 2 (sources selected by HP_MAP) or main slot 4 (all
// others), and registers the encoded status word and the CPU interrupt line.
// Peripheral slot 0 is the DMA group. The main level is hidden while a
// critical source is pending. Assumes level-sensitive requests and a bus
// master that holds each write for a single cycle.
module irq_status_encoder
    import irq_enc_pkg::*;
#(
    parameter logic [PER_SLOTS-1:0] HP_MAP = 32'h0000_000E
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CRIT_SLOTS-1:0] crit_req,
    input  logic [MAIN_SLOTS-1:0] main_req,
    input  logic [PER_SLOTS-1:0]  per_req,
    input  logic [DMA_BITS-1:0]   dma_evt,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [WORD_W-1:0]     status_o,
    output logic                  irq_o
);

    logic                  we_main_mask;
    logic                  we_per_mask;
    logic                  we_dma_pend;
    logic                  we_dma_mask;
    logic [MAIN_SLOTS-1:0] main_mask_q;
    logic [PER_SLOTS-1:0]  per_mask_q;
    logic [MAIN_SLOTS-1:0] main_en;
    logic [PER_SLOTS-1:0]  per_en;
    logic [DMA_BITS-1:0]   dma_pend_q;
    logic [DMA_BITS-1:0]   dma_mask_q;
    logic                  dma_active;
    logic [PER_SLOTS-1:0]  per_raw;
    logic [PER_SLOTS-1:0]  per_act;
    logic                  hp_any;
    logic                  lp_any;
    logic [CRIT_SLOTS-1:0] crit_eff;
    logic [MAIN_SLOTS-1:0] main_eff;
    logic                  crit_any;
    logic                  main_any;
    logic                  per_any;
    logic [CRIT_NUM_W-1:0] crit_idx;
    logic [MAIN_NUM_W-1:0] main_idx;
    logic [PER_NUM_W-1:0]  per_idx;
    logic [WORD_W-1:0]     status_d;
    logic                  unused_slot_pins;

    // Write strobe decode
    assign we_main_mask = bus_we && (bus_addr == SEL_MAIN_MASK);
    assign we_per_mask  = bus_we && (bus_addr == SEL_PER_MASK);
    assign we_dma_pend  = bus_we && (bus_addr == SEL_DMA_PEND);
    assign we_dma_mask  = bus_we && (bus_addr == SEL_DMA_MASK);

    irq_mask_regs #(
        .MAIN_SLOTS (MAIN_SLOTS),
        .PER_SLOTS  (PER_SLOTS),
        .WORD_W     (WORD_W)
    ) u_masks (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_we     (we_main_mask),
        .per_we      (we_per_mask),
        .wdata       (bus_wdata),
        .main_mask_q (main_mask_q),
        .per_mask_q  (per_mask_q),
        .main_en     (main_en),
        .per_en      (per_en)
    );

    irq_dma_group #(
        .BITS (DMA_BITS)
    ) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (dma_evt),
        .clr_we    (we_dma_pend),
        .clr_data  (bus_wdata[DMA_BITS-1:0]),
        .mask_we   (we_dma_mask),
        .mask_data (bus_wdata[DMA_BITS-1:0]),
        .pend_q    (dma_pend_q),
        .mask_q    (dma_mask_q),
        .active    (dma_active)
    );

    // Internally fed slots take the place of these pin bits
    assign unused_slot_pins = ^{crit_req[CRIT_HP_SLOT], main_req[MAIN_LP_SLOT],
                                per_req[PER_DMA_SLOT]};

    // Peripheral vector with the DMA group in slot 0, then masked
    always_comb begin
        per_raw               = per_req;
        per_raw[PER_DMA_SLOT] = dma_active;
    end
    assign per_act = per_raw & per_en;

    // Split active peripherals into the high- and low-priority paths
    assign hp_any = |(per_act & HP_MAP);
    assign lp_any = |(per_act & ~HP_MAP);

    // Critical vector with the high-priority peripheral path in its slot
    always_comb begin
        crit_eff               = crit_req;
        crit_eff[CRIT_HP_SLOT] = hp_any;
    end

    // Main vector with the low-priority peripheral path, then masked
    always_comb begin
        main_eff               = main_req;
        main_eff[MAIN_LP_SLOT] = lp_any;
        main_eff               = main_eff & main_en;
    end

    irq_lowest_enc #(.N(CRIT_SLOTS), .W(CRIT_NUM_W)) u_enc_crit (
        .req (crit_eff), .any (crit_any), .idx (crit_idx)
    );

    irq_lowest_enc #(.N(MAIN_SLOTS), .W(MAIN_NUM_W)) u_enc_main (
        .req (main_eff), .any (main_any), .idx (main_idx)
    );

    irq_lowest_enc #(.N(PER_SLOTS), .W(PER_NUM_W)) u_enc_per (
        .req (per_act), .any (per_any), .idx (per_idx)
    );

    // Compose the next status word; the main level is hidden under critical
    always_comb begin
        status_d = '0;
        status_d[CRIT_FLAG_BIT]                   = crit_any;
        status_d[CRIT_NUM_LSB +: CRIT_NUM_W]      = crit_idx;
        if (main_any && !crit_any) begin
            status_d[MAIN_FLAG_BIT]               = 1'b1;
            status_d[MAIN_NUM_LSB +: MAIN_NUM_W]  = main_idx;
        end
        status_d[PER_FLAG_BIT]                    = per_any;
        status_d[PER_NUM_LSB +: PER_NUM_W]        = per_idx;
    end

    // Status word and CPU line share one register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            status_o <= status_d;
            irq_o    <= status_d[CRIT_FLAG_BIT] | status_d[MAIN_FLAG_BIT]
                      | status_d[PER_FLAG_BIT];
        end
    end

    // Read data multiplexer
    always_comb begin
        case (bus_addr)
            SEL_STATUS:    bus_rdata = status_o;
            SEL_MAIN_MASK: bus_rdata = WORD_W'(main_mask_q);
            SEL_PER_MASK:  bus_rdata = WORD_W'(per_mask_q);
            SEL_DMA_PEND:  bus_rdata = WORD_W'(dma_pend_q);
            SEL_DMA_MASK:  bus_rdata = WORD_W'(dma_mask_q);
            default:       bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_encoder_chk.sv
// Module: irq_status_encoder_chk
// Property checker bound to irq_status_encoder. Assumes reset is asserted
// at the first clock edge and that dma_evt pulses are sampled on every edge.
module irq_status_encoder_chk
    import irq_enc_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [WORD_W-1:0]     status_o,
    input logic                  irq_o,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [WORD_W-1:0]     bus_wdata,
    input logic [DMA_BITS-1:0]   dma_evt,
    input logic [DMA_BITS-1:0]   dma_pend_q,
    input logic [MAIN_SLOTS-1:0] main_mask_q
);

    // R1: reserved bits are zero and an idle critical level carries number 0
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~32'h3F3F_0700) == 32'd0)
        && (status_o[CRIT_FLAG_BIT] || (status_o[9:8] == 2'd0)));

    // R5: main level hidden while critical is pending
    a_r5_main_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[CRIT_FLAG_BIT] |-> (status_o[21:16] == 6'd0));

    // R8: an event pulse sets its pending bit on the next edge
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_evt) |=> ((dma_pend_q & $past(dma_evt)) == $past(dma_evt)));

    // R8: written ones clear pending bits that had no event in that cycle
    a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == SEL_DMA_PEND))
        |=> ((dma_pend_q & $past(bus_wdata) & ~$past(dma_evt)) == '0));

    // R10: the CPU line follows the three level flags
    a_r10_line_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_o[CRIT_FLAG_BIT] | status_o[MAIN_FLAG_BIT]
                  | status_o[PER_FLAG_BIT]));

    // R11: reset clears status and pending, and sets all main mask bits
    a_r11_reset_values: assert property (@(posedge clk)
        !rst_n |=> ((status_o == '0) && !irq_o && (dma_pend_q == '0)
                    && (main_mask_q == '1)));

endmodule

bind irq_status_encoder irq_status_encoder_chk u_chk (.*);

// File: tb/irq_status_encoder_tb.sv
// Testbench for irq_status_encoder: a vector table followed by directed tests.
module irq_status_encoder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  crit_req;
    logic [16:0] main_req;
    logic [31:0] per_req;
    logic [31:0] dma_evt;
    logic        bus_we;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] status_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_status_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .crit_req  (crit_req),
        .main_req  (main_req),
        .per_req   (per_req),
        .dma_evt   (dma_evt),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );

    // Row layout: crit[85:82] main[81:65] per[64:33] status[32:1] irq[0]
    localparam int NROWS = 13;
    localparam logic [85:0] VEC [NROWS] = '{
        {4'h0, 17'h00000, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R1 idle
        {4'h8, 17'h00000, 32'h0000_0000, 32'h0000_0700, 1'b1}, // R1 crit 3
        {4'h4, 17'h00000, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 crit pin 2
        {4'h0, 17'h00010, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 main pin 4
        {4'h0, 17'h10000, 32'h0000_0000, 32'h0030_0000, 1'b1}, // R1 main 16
        {4'h0, 17'h00028, 32'h0000_0000, 32'h0023_0000, 1'b1}, // R2 main 3,5
        {4'h0, 17'h00000, 32'h8000_0000, 32'h3F24_0000, 1'b1}, // R4 low path
        {4'h0, 17'h00000, 32'h0000_0004, 32'h2200_0600, 1'b1}, // R4 high path
        {4'h0, 17'h00000, 32'h8000_0004, 32'h2200_0600, 1'b1}, // R5 both paths
        {4'h1, 17'h00001, 32'h0000_0000, 32'h0000_0400, 1'b1}, // R5 crit 0 hides main
        {4'hA, 17'h00002, 32'h0000_0000, 32'h0000_0500, 1'b1}, // R2 crit 1,3
        {4'h0, 17'h00000, 32'h0000_0101, 32'h2824_0000, 1'b1}, // R3 per pin 0
        {4'h0, 17'h00002, 32'h0000_0100, 32'h2821_0000, 1'b1}  // R2 main 1 vs slot 4
    };

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive(input logic [3:0] c, input logic [16:0] m,
                         input logic [31:0] p);
        @(negedge clk);
        crit_req = c;
        main_req = m;
        per_req  = p;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; crit_req = '0; main_req = '0; per_req = '0;
        dma_evt = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 reset values
        check("R11 status", status_o, 32'h0);
        check("R11 irq", {31'd0, irq_o}, 32'h0);
        bus_read(3'd1, rd); check("R11 main mask", rd, 32'h0001_FFFF);
        bus_read(3'd2, rd); check("R11 per mask", rd, 32'hFFFF_FFFF);
        bus_read(3'd3, rd); check("R11 dma pend", rd, 32'h0);
        bus_read(3'd4, rd); check("R11 dma mask", rd, 32'hFFFF_FFFF);
        bus_read(3'd5, rd); check("R12 unused addr", rd, 32'h0);

        // R6 R7: everything masked after reset
        drive(4'h0, 17'h1FFFF, 32'hFFFF_FFFF);
        settle();
        check("R6 R7 all masked", status_o, 32'h0);

        // Open main and peripheral masks
        drive(4'h0, 17'h0, 32'h0);
        bus_write(3'd1, 32'h0);
        bus_write(3'd2, 32'h0);

        // Vector table
        for (int i = 0; i < NROWS; i++) begin
            drive(VEC[i][85:82], VEC[i][81:65], VEC[i][64:33]);
            settle();
            check($sformatf("R1 R2 R3 R4 R5 row %0d status", i), status_o, VEC[i][32:1]);
            check($sformatf("R10 row %0d irq", i), {31'd0, irq_o}, {31'd0, VEC[i][0]});
        end

        // R10 latency: unchanged before the edge, updated after one edge
        drive(4'h0, 17'h0, 32'h0);
        settle();
        @(negedge clk);
        crit_req = 4'h1;
        #1;
        check("R10 before edge", {31'd0, irq_o}, 32'h0);
        @(negedge clk);
        check("R10 after one edge irq", {31'd0, irq_o}, 32'h1);
        check("R10 after one edge status", status_o, 32'h0000_0400);

        // R12 write to status ignored
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_read(3'd0, rd);
        check("R12 status read-only", rd, 32'h0000_0400);
        drive(4'h0, 17'h0, 32'h0);

        // R6 mask bit 16-n disables main n
        bus_write(3'd1, 32'h0000_0800);
        drive(4'h0, 17'h00020, 32'h0);
        settle();
        check("R6 main 5 masked", status_o, 32'h0);
        drive(4'h0, 17'h00060, 32'h0);
        settle();
        check("R6 main 6 open", status_o, 32'h0026_0000);
        bus_write(3'd1, 32'h0000_1000);
        drive(4'h0, 17'h0, 32'h0000_0100);
        settle();
        check("R6 slot 4 masked", status_o, 32'h2800_0000);
        bus_write(3'd1, 32'h0);

        // R7 mask bit 31-n disables peripheral n
        bus_write(3'd2, 32'h0080_0000);
        drive(4'h0, 17'h0, 32'h0000_0100);
        settle();
        check("R7 per 8 masked", status_o, 32'h0);
        drive(4'h0, 17'h0, 32'h0000_0300);
        settle();
        check("R7 per 9 open", status_o, 32'h2924_0000);
        bus_write(3'd2, 32'h0);
        drive(4'h0, 17'h0, 32'h0);

        // R8 R9 DMA group
        @(negedge clk); dma_evt = 32'h0000_0020;
        @(negedge clk); dma_evt = 32'h0;
        bus_read(3'd3, rd);
        check("R8 event sets pending", rd, 32'h0000_0020);
        settle();
        check("R9 masked pending silent", status_o, 32'h0);
        bus_write(3'd4, 32'hFFFF_FFDF);
        settle();
        check("R9 unmasked pending to per 0", status_o, 32'h2024_0000);
        bus_write(3'd2, 32'h8000_0000);
        settle();
        check("R7 per mask gates DMA group", status_o, 32'h0);
        bus_write(3'd2, 32'h0);
        bus_write(3'd3, 32'h0000_0020);
        bus_read(3'd3, rd);
        check("R8 write one clears", rd, 32'h0);
        settle();
        check("R8 cleared group silent", status_o, 32'h0);

        // R8 set wins over clear in the same cycle
        @(negedge clk);
        dma_evt = 32'h8; bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h8;
        @(negedge clk);
        dma_evt = 32'h0; bus_we = 1'b0; bus_wdata = 32'h0;
        bus_read(3'd3, rd);
        check("R8 set beats clear", rd, 32'h0000_0008);
        bus_write(3'd3, 32'h8);
        bus_read(3'd3, rd);
        check("R8 final clear", rd, 32'h0);

        finish_run();
    end

endmodule